// File: doc/BRIEF.md
# Multi-Mode Shift Register

A word-wide register intended for an ALU datapath. On every rising clock edge it either keeps its contents or applies one of five operations: a parallel load, an arithmetic right shift, a logical right shift, a one-place rotate toward bit 0, or a one-place left shift. Each operation has its own active-high command line. When several lines are high together, a fixed priority picks one of them.

Every bit has its own next-state selector. Interior bits take their value from a neighbour. The two end bits take a different source for each operation. A second output, `shift_out`, gives the bit that left the word on the most recent shift or rotate. A synchronous reset clears both the word and `shift_out`.

Top module: `shreg_multimode`

## Requirements
- R1: A high `rst` at a rising edge clears `q` and `shift_out` to 0, whatever the command lines hold.
- R2: `cmd_load` copies `load_data` into `q` at the edge.
- R3: `cmd_asr` moves every bit one place toward bit 0 and keeps bit 15 at its old value.
- R4: `cmd_lsr` moves every bit one place toward bit 0 and writes 0 into bit 15.
- R5: `cmd_ror` moves every bit one place toward bit 0 and writes the old bit 0 into bit 15. Sixteen rotates in a row return the original word.
- R6: `cmd_shl` moves every bit one place toward bit 15 and writes 0 into bit 0.
- R7: With every command line low, `q` keeps its value and `shift_out` becomes 0.
- R8: When several command lines are high, only one is applied. The order from highest to lowest is load, arithmetic right, logical right, rotate right, shift left.
- R9: After a right shift or a rotate, `shift_out` equals the old bit 0. After a left shift, it equals the old bit 15. After a load it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Parallel load command |
| cmd_asr | input | 1 | Arithmetic shift right command |
| cmd_lsr | input | 1 | Logical shift right command |
| cmd_ror | input | 1 | Rotate right command |
| cmd_shl | input | 1 | Shift left command |
| load_data | input | 16 | Parallel data word |
| q | output | 16 | Register contents |
| shift_out | output | 1 | Bit that left the word on the last move |

## Verification
The assertions assume that every command line and `load_data` hold known values at each rising edge, and that `rst` is high on the first edge. The bench drives all inputs on the falling edge from fixed values and holds reset over the first edges. Each property is therefore sampled on stable, defined data. The stimulus uses random words with the sign bit both set and clear, and walks through every pair and group of commands that the priority order has to resolve.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
   typedef enum logic [2:0] {
      OP_HOLD = 3'd0,
      OP_LOAD = 3'd1,
      OP_ASR  = 3'd2,
      OP_LSR  = 3'd3,
      OP_ROR  = 3'd4,
      OP_SHL  = 3'd5
   } shreg_op_e;

   typedef struct packed {
      logic load;
      logic asr;
      logic lsr;
      logic ror;
      logic shl;
   } shreg_cmd_t;
endpackage

// File: rtl/shreg_cmd_arb.sv
module shreg_cmd_arb
   import shreg_pkg::*;
(
   input  shreg_cmd_t cmd,
   output shreg_op_e  op
);
   // fixed priority: load > asr > lsr > ror > shl
   always_comb begin
      if (cmd.load)      op = OP_LOAD;
      else if (cmd.asr)  op = OP_ASR;
      else if (cmd.lsr)  op = OP_LSR;
      else if (cmd.ror)  op = OP_ROR;
      else if (cmd.shl)  op = OP_SHL;
      else               op = OP_HOLD;
   end
endmodule

// File: rtl/shreg_bit_mux.sv
module shreg_bit_mux
   import shreg_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  shreg_op_e        op,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] nxt,
   output logic             out_bit
);
   localparam int MSB = WIDTH - 1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_hi;
      logic from_lo;
      if (i == MSB) begin : g_top
         always_comb begin
            case (op)
               OP_ASR:  from_hi = cur[MSB];
               OP_ROR:  from_hi = cur[0];
               default: from_hi = 1'b0;
            endcase
         end
      end else begin : g_mid_hi
         assign from_hi = cur[i+1];
      end
      if (i == 0) begin : g_bot
         assign from_lo = 1'b0;
      end else begin : g_mid_lo
         assign from_lo = cur[i-1];
      end

      always_comb begin
         case (op)
            OP_LOAD:               nxt[i] = din[i];
            OP_ASR, OP_LSR, OP_ROR: nxt[i] = from_hi;
            OP_SHL:                nxt[i] = from_lo;
            default:               nxt[i] = cur[i];
         endcase
      end
   end

   always_comb begin
      case (op)
         OP_ASR, OP_LSR, OP_ROR: out_bit = cur[0];
         OP_SHL:                 out_bit = cur[MSB];
         default:                out_bit = 1'b0;
      endcase
   end
endmodule

// File: rtl/shreg_multimode.sv
module shreg_multimode
   import shreg_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_load,
   input  logic             cmd_asr,
   input  logic             cmd_lsr,
   input  logic             cmd_ror,
   input  logic             cmd_shl,
   input  logic [WIDTH-1:0] load_data,
   output logic [WIDTH-1:0] q,
   output logic             shift_out
);
   if (WIDTH < 2) begin : g_bad_width
      $error("shreg_multimode: WIDTH must be at least 2");
   end

   shreg_cmd_t       cmd;
   shreg_op_e        op;
   logic [WIDTH-1:0] q_nxt;
   logic             so_nxt;

   assign cmd = '{load: cmd_load, asr: cmd_asr, lsr: cmd_lsr,
                  ror: cmd_ror, shl: cmd_shl};

   shreg_cmd_arb i_arb (
      .cmd (cmd),
      .op  (op)
   );

   shreg_bit_mux #(.WIDTH(WIDTH)) i_mux (
      .op      (op),
      .cur     (q),
      .din     (load_data),
      .nxt     (q_nxt),
      .out_bit (so_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         q         <= '0;
         shift_out <= 1'b0;
      end else begin
         q         <= q_nxt;
         shift_out <= so_nxt;
      end
   end
endmodule

// File: rtl/shreg_multimode_chk.sv
module shreg_multimode_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             cmd_load,
   input logic             cmd_asr,
   input logic             cmd_lsr,
   input logic             cmd_ror,
   input logic             cmd_shl,
   input logic [WIDTH-1:0] load_data,
   input logic [WIDTH-1:0] q,
   input logic             shift_out
);
   logic none;
   assign none = !(cmd_load || cmd_asr || cmd_lsr || cmd_ror || cmd_shl);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (q == '0 && !shift_out));

   // R2
   load_copy_chk: assert property (@(posedge clk) disable iff (rst)
      cmd_load |=> (q == $past(load_data) && !shift_out));

   // R3
   asr_sign_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_asr && !cmd_load) |=>
         (q[WIDTH-1] == $past(q[WIDTH-1]) && q[WIDTH-2:0] == $past(q[WIDTH-1:1])));

   // R4
   lsr_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_lsr && !cmd_load && !cmd_asr) |=>
         (!q[WIDTH-1] && shift_out == $past(q[0])));

   // R5
   ror_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_ror && !cmd_load && !cmd_asr && !cmd_lsr) |=>
         (q[WIDTH-1] == $past(q[0]) && shift_out == $past(q[0])));

   // R6
   shl_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_shl && !cmd_load && !cmd_asr && !cmd_lsr && !cmd_ror) |=>
         (!q[0] && shift_out == $past(q[WIDTH-1])));

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      none |=> ($stable(q) && !shift_out));
endmodule

bind shreg_multimode shreg_multimode_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_shreg_multimode.sv
module test_shreg_multimode;
   localparam int W = 16;

   typedef struct {
      logic [W-1:0] q;
      logic         so;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst;
   logic         cmd_load, cmd_asr, cmd_lsr, cmd_ror, cmd_shl;
   logic [W-1:0] load_data;
   logic [W-1:0] q;
   logic         shift_out;

   item_t        sb[$];
   logic [W-1:0] m_q  = '0;
   logic         m_so = 1'b0;
   int           n_run  = 0;
   int           n_fail = 0;
   bit           done   = 0;

   always #2.5 clk = ~clk;

   shreg_multimode #(.WIDTH(W)) i_shreg_multimode (.*);

   // driver: c = {load, asr, lsr, ror, shl}
   task automatic step(input logic r, input logic [4:0] c,
                       input logic [W-1:0] d, input string tag);
      item_t it;
      @(negedge clk);
      rst = r;
      {cmd_load, cmd_asr, cmd_lsr, cmd_ror, cmd_shl} = c;
      load_data = d;
      if (r) begin
         m_q = '0; m_so = 1'b0;
      end else if (c[4]) begin
         m_q = d; m_so = 1'b0;
      end else if (c[3]) begin
         m_so = m_q[0]; m_q = {m_q[W-1], m_q[W-1:1]};
      end else if (c[2]) begin
         m_so = m_q[0]; m_q = {1'b0, m_q[W-1:1]};
      end else if (c[1]) begin
         m_so = m_q[0]; m_q = {m_q[0], m_q[W-1:1]};
      end else if (c[0]) begin
         m_so = m_q[W-1]; m_q = {m_q[W-2:0], 1'b0};
      end else begin
         m_so = 1'b0;
      end
      it.q = m_q; it.so = m_so; it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t e;
            e = sb.pop_front();
            n_run++;
            if (q !== e.q || shift_out !== e.so) begin
               n_fail++;
               $display("FAIL %s: q=%h so=%b expected q=%h so=%b",
                        e.tag, q, shift_out, e.q, e.so);
            end
         end
      end
   end

   initial begin
      #(5ns * 20000);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] w;
      rst = 1'b1;
      {cmd_load, cmd_asr, cmd_lsr, cmd_ror, cmd_shl} = '0;
      load_data = '0;
      // R1: reset with every command high
      step(1, 5'b11111, 16'hFFFF, "R1");
      step(1, 5'b10000, 16'hA5A5, "R1");
      // R2: loads
      step(0, 5'b10000, 16'h8001, "R2");
      step(0, 5'b10000, 16'h7FFE, "R2");
      // R1: reset after data present
      step(1, 5'b00000, 16'h0, "R1");
      for (int k = 0; k < 6; k++) begin
         w = $urandom; w[W-1] = k[0];
         step(0, 5'b10000, w, "R2");
         step(0, 5'b01000, 16'h0, "R3 R9");
         step(0, 5'b01000, 16'h0, "R3 R9");
         step(0, 5'b10000, w, "R2");
         step(0, 5'b00100, 16'h0, "R4 R9");
         step(0, 5'b00100, 16'h0, "R4 R9");
         step(0, 5'b10000, w, "R2");
         step(0, 5'b00010, 16'h0, "R5 R9");
         step(0, 5'b00001, 16'h0, "R6 R9");
         step(0, 5'b00001, 16'h0, "R6 R9");
         step(0, 5'b00000, 16'hFFFF, "R7");
         step(0, 5'b00000, 16'h1234, "R7");
      end
      // R5: full rotation returns the word
      step(0, 5'b10000, 16'hC3A1, "R2");
      for (int k = 0; k < W; k++) step(0, 5'b00010, 16'h0, "R5");
      // R3: negative word shifted all the way
      step(0, 5'b10000, 16'h8000, "R2");
      for (int k = 0; k < W; k++) step(0, 5'b01000, 16'h0, "R3");
      // R6: shift left out the top
      step(0, 5'b10000, 16'h8001, "R2");
      step(0, 5'b00001, 16'h0, "R6 R9");
      step(0, 5'b00001, 16'h0, "R6 R9");
      // R8: priority combinations
      for (int c = 3; c < 32; c++) begin
         if ($countones(c) > 1) begin
            w = $urandom;
            step(0, 5'b10000, w ^ 16'h8001, "R2");
            step(0, c[4:0], w, "R8");
         end
      end
      @(negedge clk);
      {cmd_load, cmd_asr, cmd_lsr, cmd_ror, cmd_shl} = '0;
      rst = 1'b0;
      while (sb.size() > 0) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule